// File: doc/BRIEF.md
# Ancillary Packet Checksum Regenerator

This block sits in a 10-bit video word stream just ahead of a serializer. It looks for ancillary data packets and keeps a running 9-bit checksum over each packet's body. When the packet's checksum word arrives, the block compares the received value with the one it computed. If any of the nine value bits disagree, it overwrites the whole word with the correct value and its parity bit. Every other word passes through untouched.

A packet starts with a three-word marker: a word of all zeros, then two words of all ones. Three header words follow: an identifier, a secondary identifier, and a count word. Bits 7:0 of the count word give the number of user words. After the user words comes the checksum slot. Detection only takes place while the region qualifier is high. Correction only takes place while the active-low insertion enable is low. The output is the input stream delayed by one clock, with in_valid carried along as out_valid.

The parser is a state machine with eight states:
- HUNT waits for the zero word.
- FLAG_A has seen the zero word.
- FLAG_B has seen zero then one all-ones word.
- ID, SID and COUNT take the three header words.
- USER counts down the user words.
- SUM is the checksum slot.

Its transitions are:
- start (HUNT to FLAG_A on a zero word).
- flag-advance (FLAG_A to FLAG_B, then FLAG_B to ID, on all-ones words).
- flag-restart (to FLAG_A on a zero word from any state).
- flag-miss (FLAG_A or FLAG_B to HUNT on any other word).
- header-step (ID to SID to COUNT).
- empty-packet (COUNT to SUM when the count is zero).
- body (COUNT to USER, then staying in USER until the last user word, then USER to SUM).
- finish (SUM to HUNT).
- region-drop (any state to HUNT when a valid word arrives with the qualifier low).

Top module: `anc_csum_fixer`

## Requirements
- R1: out_valid equals in_valid delayed by one clock. When out_valid is high, out_word carries the word presented one clock earlier, unless R4 replaced it.
- R2: While anc_region is high, the valid word sequence 0x000, 0x3FF, 0x3FF starts a packet. The next three valid words are the ID word, the secondary ID word and the count word. Bits 7:0 of the count word give the number of user words, and the checksum slot follows the last user word.
- R3: The computed checksum s is the sum, modulo 512, of bits 8:0 of the ID word, the secondary ID word, the count word and every user word. A replacement word is {~s[8], s[8:0]}, so bit 9 is the inverse of bit 8.
- R4: At the checksum slot, the word is replaced by the R3 word if its bits 8:0 differ from s in at least one position.
- R5: A checksum word whose bits 8:0 equal s is forwarded unchanged, even when its bit 9 is wrong.
- R6: While ins_en_n is high, every word is forwarded unchanged. This includes a wrong checksum.
- R7: Words outside the checksum slot (video, markers, headers, user words) are never modified.
- R8: A 0x000 word at any packet body position (from the ID word through the checksum slot) abandons the packet without insertion. That word is taken as the first word of a new marker.
- R9: A valid word with anc_region low is never modified and abandons any packet in progress.
- R10: Cycles with in_valid low do not advance parsing. A packet whose words are separated by idle cycles is corrected exactly as if its words were back to back.
- R11: A count word with bits 7:0 equal to zero places the checksum slot directly after the count word.
- R12: While rst_n is low, out_valid and out_word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 10 | Incoming video word |
| in_valid | input | 1 | in_word holds a word this clock |
| anc_region | input | 1 | High where ancillary packets may be detected |
| ins_en_n | input | 1 | Low enables checksum correction |
| out_word | output | 10 | Forwarded word, checksum corrected |
| out_valid | output | 1 | out_word holds a word |

## Verification
Directed packets are sent with four kinds of checksum word:
- A correct word, which must pass unchanged.
- A word with value bits flipped, which must be replaced.
- A word with only its parity bit flipped, which must pass unchanged. This separates a nine-bit compare from a ten-bit compare.
- A wrong word while correction is disabled, which must pass unchanged.

Packet lengths cover an empty packet and one long enough for the sum to wrap past 511, which exposes a sum that is not taken modulo 512. Abort patterns, a qualifier dropped in the middle of a packet, and idle gaps between packet words show whether the state machine loses or keeps its place. Non-packet runs of 0x000 and 0x3FF show that a partial marker never alters a word.

// File: rtl/anc_csum_pkg.sv
package anc_csum_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_FLAG_A,
        ST_FLAG_B,
        ST_ID,
        ST_SID,
        ST_COUNT,
        ST_USER,
        ST_SUM
    } anc_state_e;

endpackage

// File: rtl/anc_pkt_tracker.sv
module anc_pkt_tracker
    import anc_csum_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word,
    input  logic              valid,
    input  logic              region,
    output logic              sum_load,
    output logic              sum_add,
    output logic              cs_slot
);

    localparam logic [DATA_W-1:0] WORD_ZERO = '0;
    localparam logic [DATA_W-1:0] WORD_ONES = '1;
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0]  CNT_NONE  = '0;

    anc_state_e        state, state_nxt;
    logic [CNT_W-1:0]  remain;
    logic              is_zero, is_ones, live;

    assign is_zero = (word == WORD_ZERO);
    assign is_ones = (word == WORD_ONES);
    assign live    = valid && region;

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (valid) begin
            if (!region) begin
                state_nxt = ST_HUNT;                        // region-drop
            end else begin
                unique case (state)
                    ST_HUNT:   if (is_zero) state_nxt = ST_FLAG_A;
                    ST_FLAG_A: begin
                        if (is_ones)       state_nxt = ST_FLAG_B;
                        else if (is_zero)  state_nxt = ST_FLAG_A;
                        else               state_nxt = ST_HUNT;
                    end
                    ST_FLAG_B: begin
                        if (is_ones)       state_nxt = ST_ID;
                        else if (is_zero)  state_nxt = ST_FLAG_A;
                        else               state_nxt = ST_HUNT;
                    end
                    ST_ID:     state_nxt = is_zero ? ST_FLAG_A : ST_SID;
                    ST_SID:    state_nxt = is_zero ? ST_FLAG_A : ST_COUNT;
                    ST_COUNT: begin
                        if (is_zero)
                            state_nxt = ST_FLAG_A;
                        else if (word[CNT_W-1:0] == CNT_NONE)
                            state_nxt = ST_SUM;             // empty-packet
                        else
                            state_nxt = ST_USER;
                    end
                    ST_USER: begin
                        if (is_zero)               state_nxt = ST_FLAG_A;
                        else if (remain == CNT_ONE) state_nxt = ST_SUM;
                        else                       state_nxt = ST_USER;
                    end
                    ST_SUM:    state_nxt = is_zero ? ST_FLAG_A : ST_HUNT;
                    default:   state_nxt = ST_HUNT;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // user-word countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (live && !is_zero) begin
            if (state == ST_COUNT)     remain <= word[CNT_W-1:0];
            else if (state == ST_USER) remain <= remain - CNT_ONE;
        end
    end

    // outputs
    always_comb begin
        sum_load = 1'b0;
        sum_add  = 1'b0;
        cs_slot  = 1'b0;
        if (region && !is_zero) begin
            unique case (state)
                ST_ID:                    sum_load = valid;
                ST_SID, ST_COUNT, ST_USER: sum_add = valid;
                ST_SUM:                   cs_slot  = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/anc_sum_acc.sv
module anc_sum_acc #(
    parameter int SUM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             add,
    input  logic [SUM_W-1:0] val,
    output logic [SUM_W-1:0] sum
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sum <= '0;
        else if (load) sum <= val;
        else if (add)  sum <= sum + val;   // wraps modulo 2**SUM_W
    end

endmodule

// File: rtl/anc_word_emit.sv
module anc_word_emit #(
    parameter int DATA_W = 10,
    localparam int SUM_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word,
    input  logic              valid,
    input  logic              cs_slot,
    input  logic              ins_en_n,
    input  logic [SUM_W-1:0]  sum,
    output logic [DATA_W-1:0] out_word,
    output logic              out_valid
);

    logic [DATA_W-1:0] fixed;
    logic              mismatch, replace;

    assign fixed    = {~sum[SUM_W-1], sum};
    assign mismatch = (word[SUM_W-1:0] != sum);
    assign replace  = cs_slot && !ins_en_n && mismatch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= valid;
            if (valid) out_word <= replace ? fixed : word;
        end
    end

endmodule

// File: rtl/anc_csum_fixer.sv
module anc_csum_fixer #(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_word,
    input  logic              in_valid,
    input  logic              anc_region,
    input  logic              ins_en_n,
    output logic [DATA_W-1:0] out_word,
    output logic              out_valid
);

    localparam int SUM_W = DATA_W - 1;

    logic             sum_load, sum_add, cs_slot;
    logic [SUM_W-1:0] sum;

    anc_pkt_tracker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (in_word),
        .valid    (in_valid),
        .region   (anc_region),
        .sum_load (sum_load),
        .sum_add  (sum_add),
        .cs_slot  (cs_slot)
    );

    anc_sum_acc #(.SUM_W(SUM_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sum_load),
        .add   (sum_add),
        .val   (in_word[SUM_W-1:0]),
        .sum   (sum)
    );

    anc_word_emit #(.DATA_W(DATA_W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .word      (in_word),
        .valid     (in_valid),
        .cs_slot   (cs_slot),
        .ins_en_n  (ins_en_n),
        .sum       (sum),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/anc_csum_chk.sv
module anc_csum_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_word,
    input logic              in_valid,
    input logic              anc_region,
    input logic              ins_en_n,
    input logic [DATA_W-1:0] out_word,
    input logic              out_valid,
    input logic              cs_slot
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    a_r3_parity_on_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word != $past(in_word)) |-> (out_word[DATA_W-1] != out_word[DATA_W-2]));

    a_r5_value_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[DATA_W-2:0] == $past(in_word[DATA_W-2:0])) |-> (out_word == $past(in_word)));

    a_r6_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ins_en_n) |=> (out_word == $past(in_word)));

    a_r7_only_slot_changes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word != $past(in_word)) |-> $past(cs_slot));

    a_r9_region_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !anc_region) |=> (out_word == $past(in_word)));

    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_word == '0));

endmodule

bind anc_csum_fixer anc_csum_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_word    (in_word),
    .in_valid   (in_valid),
    .anc_region (anc_region),
    .ins_en_n   (ins_en_n),
    .out_word   (out_word),
    .out_valid  (out_valid),
    .cs_slot    (cs_slot)
);

// File: tb/sim_anc_csum_fixer.sv
`timescale 1ns/1ps
module sim_anc_csum_fixer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] in_word = '0;
    logic       in_valid = 1'b0;
    logic       anc_region = 1'b0;
    logic       ins_en_n = 1'b0;
    logic [9:0] out_word;
    logic       out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    anc_csum_fixer u0 (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .anc_region(anc_region), .ins_en_n(ins_en_n),
        .out_word(out_word), .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [9:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one word, check it one clock later (R1 latency)
    task automatic push(input logic [9:0] w, exp, input string tag);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(posedge clk);
        #2;
        check(out_valid === 1'b1, "R1 out_valid", {9'd0, out_valid}, 10'd1);
        check(out_word === exp, tag, out_word, exp);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 10'h2AA;
        @(posedge clk);
        #2;
        check(out_valid === 1'b0, tag, {9'd0, out_valid}, 10'd0);
    endtask

    // mode 0: correct checksum, 1: value bits wrong, 2: parity bit wrong
    task automatic run_pkt(input string tag, input logic [9:0] did, sid,
                           input int n, input int seed, input int mode,
                           input bit gaps, input bit expect_fix);
        logic [8:0] s;
        logic [9:0] dc, good, cs_in, w;
        dc = {2'b10, 8'(n)};
        s  = did[8:0] + sid[8:0] + dc[8:0];
        push(10'h000, 10'h000, {tag, " R7 flag"});  if (gaps) idle("R10 gap");
        push(10'h3FF, 10'h3FF, {tag, " R7 flag"});  if (gaps) idle("R10 gap");
        push(10'h3FF, 10'h3FF, {tag, " R7 flag"});  if (gaps) idle("R10 gap");
        push(did, did, {tag, " R7 id"});            if (gaps) idle("R10 gap");
        push(sid, sid, {tag, " R7 sid"});           if (gaps) idle("R10 gap");
        push(dc, dc, {tag, " R7 count"});           if (gaps) idle("R10 gap");
        for (int i = 0; i < n; i++) begin
            w = 10'h100 | 10'((seed + i * 37) & 8'hFF);
            s = s + w[8:0];
            push(w, w, {tag, " R7 user"});
            if (gaps) idle("R10 gap");
        end
        good  = {~s[8], s};
        cs_in = (mode == 0) ? good : (mode == 1) ? (good ^ 10'h005) : (good ^ 10'h200);
        push(cs_in, expect_fix ? good : cs_in, {tag, " checksum"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(out_valid === 1'b0 && out_word === 10'h000, "R12 reset state", out_word, 10'h000);
        @(negedge clk);
        rst_n = 1'b1;
        anc_region = 1'b1;

        // plain video including partial markers
        push(10'h3FF, 10'h3FF, "R7 video");
        push(10'h000, 10'h000, "R7 video");
        push(10'h3FF, 10'h3FF, "R7 video");
        push(10'h200, 10'h200, "R7 video");
        push(10'h040, 10'h040, "R7 video");

        run_pkt("R2 R4 correct", 10'h160, 10'h101, 4, 5, 0, 0, 0);
        run_pkt("R3 R4 wrong value", 10'h1E0, 10'h1F3, 6, 90, 1, 0, 1);
        run_pkt("R3 wrap long", 10'h1FE, 10'h1FD, 40, 200, 1, 0, 1);
        run_pkt("R5 parity only", 10'h155, 10'h122, 3, 17, 2, 0, 0);
        run_pkt("R11 empty", 10'h1A0, 10'h1B0, 0, 0, 1, 0, 1);
        ins_en_n = 1'b1;
        run_pkt("R6 disabled", 10'h1E0, 10'h1F3, 6, 90, 1, 0, 0);
        ins_en_n = 1'b0;
        run_pkt("R10 gaps", 10'h133, 10'h144, 5, 60, 1, 1, 1);

        // R8 abort then non-marker words
        push(10'h000, 10'h000, "R8 flag");
        push(10'h3FF, 10'h3FF, "R8 flag");
        push(10'h3FF, 10'h3FF, "R8 flag");
        push(10'h160, 10'h160, "R8 id");
        push(10'h101, 10'h101, "R8 sid");
        push(10'h202, 10'h202, "R8 count");
        push(10'h111, 10'h111, "R8 user");
        push(10'h000, 10'h000, "R8 abort word");
        push(10'h155, 10'h155, "R8 after abort");
        push(10'h123, 10'h123, "R8 old slot untouched");
        // R8 abort that starts a new packet
        push(10'h000, 10'h000, "R8 flag");
        push(10'h3FF, 10'h3FF, "R8 flag");
        push(10'h3FF, 10'h3FF, "R8 flag");
        push(10'h160, 10'h160, "R8 id");
        push(10'h000, 10'h000, "R8 restart zero");
        push(10'h3FF, 10'h3FF, "R8 restart");
        push(10'h3FF, 10'h3FF, "R8 restart");
        push(10'h120, 10'h120, "R8 id2");
        push(10'h130, 10'h130, "R8 sid2");
        push(10'h200, 10'h200, "R8 count2");
        // sum = 0x120+0x130+0x000 = 0x250 -> 9-bit 0x050, word {~0,0x050}=0x250
        push(10'h251, 10'h250, "R8 new packet fixed");

        // R9 whole packet outside region
        anc_region = 1'b0;
        run_pkt("R9 region low", 10'h1E0, 10'h1F3, 2, 3, 1, 0, 0);
        // R9 region drops mid packet
        anc_region = 1'b1;
        push(10'h000, 10'h000, "R9 flag");
        push(10'h3FF, 10'h3FF, "R9 flag");
        push(10'h3FF, 10'h3FF, "R9 flag");
        push(10'h160, 10'h160, "R9 id");
        push(10'h101, 10'h101, "R9 sid");
        anc_region = 1'b0;
        push(10'h200, 10'h200, "R9 count out of region");
        anc_region = 1'b1;
        push(10'h1AB, 10'h1AB, "R9 slot untouched");

        idle("R1 idle");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule